// File: doc/BRIEF.md
# System Clock Under-Frequency Guard

This block watches the main system clock against a slow, independent reference signal and flags when the system clock runs below a minimum rate. The reference is brought into the system-clock domain through a two-flop synchronizer, and its rising edges are found there. The block counts system-clock cycles between successive reference edges. When the count over one reference period falls short of a programmable threshold, the system clock is judged too slow.

A too-slow verdict pulls an active-low error pin low. The pin is released only after the clock has stayed healthy for a settling interval. That interval is timed in T0 ticks, where one T0 tick is a fixed division of the system clock. The settling timer waits for the second wrap of a free-running 16-tick prescaler. Because the timer starts at whatever phase the prescaler happens to hold, the release delay varies between 16 and 32 T0 ticks.

The guard comes out of reset armed and treats the clock as unproven, so the error pin goes low in the first cycle after reset. While reset is held, detection is suppressed. A software enable bit can disarm the guard. Disarming forces the pin high and holds the settling timer cleared.

Top module: `sysclk_guard`

## Requirements
- R1: The enable bit resets to 1. A one-cycle pulse on `arm_we` loads `arm_d` into the enable bit at the next clock edge.
- R2: While `rst` is high, `err_n` is 1 (inactive) and `too_slow` is 1. No detection takes place.
- R3: In the first cycle after `rst` falls, with the enable bit at its reset value, `err_n` is 0. It stays 0 until a healthy measurement and the settling interval have both completed.
- R4: Let P be the number of system-clock cycles between two successive synchronized rising edges of `ref_in`. At each such edge except the first after reset, `too_slow` becomes 1 if P < `thresh` and 0 if P >= `thresh`. A period exactly equal to `thresh` counts as healthy.
- R5: Whenever `too_slow` is 1 and the enable bit is 1, `err_n` is 0 in the next cycle.
- R6: When the enable bit is 0, `err_n` is 1 from the next cycle on, even if `too_slow` is 1, and the settling timer is cleared. Re-enabling while `too_slow` is 1 drives `err_n` low again.
- R7: `err_n` rises while armed only after `too_slow` has been 0 in the preceding cycle.
- R8: After `too_slow` falls with the guard armed, `err_n` stays 0 for at least 16 and at most 32 T0 ticks (one T0 tick = `T0_DIV` system cycles, default 4), plus up to three cycles of pipeline, and then goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock under supervision |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Slow reference signal, asynchronous to `clk` |
| arm_we | input | 1 | Write strobe for the enable bit |
| arm_d | input | 1 | New value of the enable bit |
| thresh | input | CNT_W | Minimum number of system cycles per reference period |
| err_n | output | 1 | Active-low clock error, registered |
| too_slow | output | 1 | Latest measurement verdict, registered |

## Verification
The hardest situation to reach from the ports is the spread of the release delay, because that delay depends on the phase of an internal prescaler that runs freely and is never visible. The bench repeats the recovery several times, each after a different amount of time spent in the slow and disarmed states, so the settling timer starts at differing prescaler phases. In every recovery it measures the cycles from the fall of `too_slow` to the rise of `err_n` against the 16 to 32 tick window. The exact-threshold boundary is reached by driving a reference period equal to `thresh` and then one cycle shorter.

// File: rtl/gd_pkg.sv
package gd_pkg;
  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_FAULT  = 2'd1,
    ST_SETTLE = 2'd2
  } err_state_t;
endpackage

// File: rtl/gd_ref_sync.sv
module gd_ref_sync (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic ref_rise
);
  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= 3'b000;
    else     sh_q <= {sh_q[1:0], ref_in};
  end

  // rising edge seen after the two synchronizing stages
  assign ref_rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/gd_rate_meter.sv
module gd_rate_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_rise,
  input  logic [CNT_W-1:0] thresh,
  output logic             slow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             primed_q;
  logic             slow_q;

  // cycles in the current period, including the edge cycle, saturating
  assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
      slow_q   <= 1'b1;
    end else if (ref_rise) begin
      cnt_q    <= '0;
      primed_q <= 1'b1;
      if (primed_q) slow_q <= (cnt_inc < thresh);
    end else begin
      cnt_q <= cnt_inc;
    end
  end

  assign slow = slow_q;
endmodule

// File: rtl/gd_tick_gen.sv
module gd_tick_gen #(
  parameter int T0_DIV = 4,
  parameter int PRE_W  = 4
) (
  input  logic clk,
  input  logic rst,
  output logic pre_wrap
);
  localparam int DIV_W = (T0_DIV > 1) ? $clog2(T0_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(T0_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;
  logic             t0_tick;

  assign t0_tick = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      div_q <= t0_tick ? '0 : div_q + 1'b1;
      if (t0_tick) pre_q <= pre_q + 1'b1;
    end
  end

  assign pre_wrap = t0_tick & (&pre_q);
endmodule

// File: rtl/gd_err_ctrl.sv
module gd_err_ctrl
  import gd_pkg::*;
#(
  parameter int REL_WRAPS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic slow,
  input  logic pre_wrap,
  output logic err_n
);
  localparam int REC_W = $clog2(REL_WRAPS + 1);
  localparam logic [REC_W-1:0] REC_LAST = REC_W'(REL_WRAPS - 1);

  err_state_t       st_q, st_d;
  logic [REC_W-1:0] rec_q;
  logic             rec_done;
  logic             err_n_q;

  assign rec_done = (st_q == ST_SETTLE) && pre_wrap && (rec_q == REC_LAST);

  always_comb begin
    st_d = st_q;
    if (!armed)     st_d = ST_OK;
    else if (slow)  st_d = ST_FAULT;
    else begin
      case (st_q)
        ST_FAULT:  st_d = ST_SETTLE;
        ST_SETTLE: if (rec_done) st_d = ST_OK;
        default:   st_d = ST_OK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_OK;
      rec_q   <= '0;
      err_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      err_n_q <= (st_d == ST_OK);
      if (st_q != ST_SETTLE || !armed || slow) rec_q <= '0;
      else if (pre_wrap)                       rec_q <= rec_q + 1'b1;
    end
  end

  assign err_n = err_n_q;
endmodule

// File: rtl/sysclk_guard.sv
module sysclk_guard #(
  parameter int CNT_W     = 16,
  parameter int T0_DIV    = 4,
  parameter int PRE_W     = 4,
  parameter int REL_WRAPS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             arm_we,
  input  logic             arm_d,
  input  logic [CNT_W-1:0] thresh,
  output logic             err_n,
  output logic             too_slow
);
  logic arm_q;
  logic ref_rise;
  logic slow;
  logic pre_wrap;

  // R1: enable bit comes out of reset set
  always_ff @(posedge clk) begin
    if (rst)         arm_q <= 1'b1;
    else if (arm_we) arm_q <= arm_d;
  end

  gd_ref_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .ref_in   (ref_in),
    .ref_rise (ref_rise)
  );

  gd_rate_meter #(.CNT_W(CNT_W)) u_meter (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (ref_rise),
    .thresh   (thresh),
    .slow     (slow)
  );

  gd_tick_gen #(.T0_DIV(T0_DIV), .PRE_W(PRE_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .pre_wrap (pre_wrap)
  );

  gd_err_ctrl #(.REL_WRAPS(REL_WRAPS)) u_err (
    .clk      (clk),
    .rst      (rst),
    .armed    (arm_q),
    .slow     (slow),
    .pre_wrap (pre_wrap),
    .err_n    (err_n)
  );

  assign too_slow = slow;
endmodule

// File: rtl/gd_checker.sv
module gd_checker #(
  parameter int T0_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic arm_q,
  input logic err_n,
  input logic too_slow
);
  localparam int MIN_HOLD = 16 * T0_DIV;
  localparam int MAX_HOLD = 32 * T0_DIV + 3;

  int unsigned hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 0;
    else if (!err_n && !too_slow && arm_q) hold_q <= hold_q + 1;
    else hold_q <= 0;
  end

  a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> err_n);

  a_r3_fault_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |=> !err_n);

  a_r5_slow_pulls_low: assert property (@(posedge clk) disable iff (rst)
    (too_slow && arm_q) |=> !err_n);

  a_r6_disarm_releases: assert property (@(posedge clk) disable iff (rst)
    !arm_q |=> err_n);

  a_r7_release_after_health: assert property (@(posedge clk) disable iff (rst)
    ($rose(err_n) && $past(arm_q)) |-> !$past(too_slow));

  a_r8_min_settle: assert property (@(posedge clk) disable iff (rst)
    ($rose(err_n) && $past(arm_q)) |-> ($past(hold_q) >= MIN_HOLD));

  a_r8_max_settle: assert property (@(posedge clk) disable iff (rst)
    hold_q <= MAX_HOLD);
endmodule

bind sysclk_guard gd_checker #(.T0_DIV(T0_DIV)) u_gd_checker (
  .clk      (clk),
  .rst      (rst),
  .arm_q    (arm_q),
  .err_n    (err_n),
  .too_slow (too_slow)
);

// File: tb/test_sysclk_guard.sv
`timescale 1ns/1ps
module test_sysclk_guard;
  localparam int CNT_W  = 16;
  localparam int T0_DIV = 4;
  localparam int LO_CYC = 16 * T0_DIV;
  localparam int HI_CYC = 32 * T0_DIV + 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ref_in = 1'b0;
  logic             arm_we = 1'b0;
  logic             arm_d = 1'b1;
  logic [CNT_W-1:0] thresh = 16'd20;
  logic             err_n;
  logic             too_slow;

  int n_chk = 0;
  int n_bad = 0;
  int ref_per = 32;
  int ph = 0;

  always #5 clk = ~clk;

  sysclk_guard #(.CNT_W(CNT_W), .T0_DIV(T0_DIV)) i_sysclk_guard (
    .clk      (clk),
    .rst      (rst),
    .ref_in   (ref_in),
    .arm_we   (arm_we),
    .arm_d    (arm_d),
    .thresh   (thresh),
    .err_n    (err_n),
    .too_slow (too_slow)
  );

  // reference generator: period ref_per system cycles, driven off the falling edge
  always @(negedge clk) begin
    if (ref_per == 0) begin
      ref_in <= 1'b0;
      ph     <= 0;
    end else begin
      ph     <= (ph + 1 >= ref_per) ? 0 : ph + 1;
      ref_in <= (ph < ref_per / 2);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_arm(input bit v);
    arm_d  = v;
    arm_we = 1'b1;
    @(negedge clk);
    arm_we = 1'b0;
  endtask

  // wait until too_slow equals v, return cycles waited (-1 on timeout)
  task automatic wait_slow(input bit v, input int lim, output int n);
    n = -1;
    for (int i = 0; i < lim; i++) begin
      if (too_slow == v) begin n = i; break; end
      @(negedge clk);
    end
  endtask

  // measure cycles from too_slow falling to err_n rising
  task automatic t_recover(input string tag);
    int w;
    int held;
    bit early;
    wait_slow(1'b0, 400, w);
    chk(w >= 0, {"R4 healthy verdict ", tag}, w, 0);
    held  = 0;
    early = 0;
    while (!err_n && held < HI_CYC + 20) begin
      if (too_slow) early = 1;
      @(negedge clk);
      held++;
    end
    chk(!early, {"R7 stayed healthy ", tag}, early, 0);
    chk(held >= LO_CYC && held <= HI_CYC, {"R8 settle window ", tag}, held, LO_CYC);
    chk(err_n == 1'b1, {"R8 released ", tag}, err_n, 1);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(6);
    chk(err_n == 1'b1, "R2 err_n in reset", err_n, 1);
    chk(too_slow == 1'b1, "R2 too_slow in reset", too_slow, 1);
    rst = 1'b0;
    cyc(1);
    chk(err_n == 1'b0, "R3 fault right after reset", err_n, 0);
    chk(err_n == 1'b0, "R1 armed by default", err_n, 0);
  endtask

  task automatic t_slow;
    int w;
    ref_per = 12;
    wait_slow(1'b1, 200, w);
    chk(w >= 0, "R4 short period is slow", too_slow, 1);
    cyc(2);
    chk(err_n == 1'b0, "R5 slow drives err_n low", err_n, 0);
  endtask

  task automatic t_boundary;
    int w;
    thresh  = 16'd24;
    ref_per = 24;
    cyc(4 * 24);
    chk(too_slow == 1'b0, "R4 period equal to thresh is healthy", too_slow, 0);
    ref_per = 23;
    cyc(4 * 23);
    chk(too_slow == 1'b1, "R4 period thresh-1 is slow", too_slow, 1);
    cyc(2);
    chk(err_n == 1'b0, "R5 boundary slow low", err_n, 0);
    thresh  = 16'd20;
    ref_per = 40;
  endtask

  task automatic t_disarm;
    bit stayed;
    ref_per = 12;
    cyc(60);
    chk(err_n == 1'b0 && too_slow == 1'b1, "R5 slow before disarm", err_n, 0);
    set_arm(1'b0);
    cyc(2);
    chk(err_n == 1'b1, "R6 disarm forces high", err_n, 1);
    stayed = 1;
    for (int i = 0; i < 80; i++) begin
      if (!err_n) stayed = 0;
      @(negedge clk);
    end
    chk(stayed, "R6 stays high while disarmed and slow", stayed, 1);
    set_arm(1'b1);
    cyc(2);
    chk(err_n == 1'b0, "R1 R6 rearm while slow goes low", err_n, 0);
  endtask

  task automatic t_disarm_settle;
    int w;
    ref_per = 32;
    wait_slow(1'b0, 400, w);
    cyc(7);
    set_arm(1'b0);
    cyc(2);
    chk(err_n == 1'b1, "R6 disarm during settle", err_n, 1);
    set_arm(1'b1);
    cyc(3);
    chk(err_n == 1'b1, "R6 rearm while healthy stays high", err_n, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_recover("first");
        t_slow();
        ref_per = 32;
        t_recover("second");
        t_boundary();
        t_recover("third");
        t_disarm();
        ref_per = 37;
        t_recover("fourth");
        ref_per = 12;
        cyc(45);
        ref_per = 32;
        t_recover("fifth");
        t_disarm_settle();
      end
      begin
        cyc(200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule